// File: doc/BRIEF.md
# Two-Stage Serial Baud Tick Generator

This block turns one fast clock into the two timing strobes a serial port needs. A sample tick paces receiver oversampling, and a bit tick paces the transmitter. The first stage can optionally thin the clock by eight. It does this with an enable pulse, so no new clock is derived. A 16-bit generator counter then fires one sample tick every `gen` enabled cycles. An 8-bit divider after it fires one bit tick on every `div + 1` sample ticks. The resulting bit rate is the selected clock rate divided by `gen * (div + 1)`.

Three control values set the block: a clock-select bit, the generator value and the divider value. Each value has its own write strobe. Software outside the block works out which pair of values comes closest to a wanted rate. Any write starts the counting chain again from zero, so the first tick after a change comes a whole period later.

Top module: `baud_gen2`

## Requirements
- R1: After reset the select bit is 0, the generator value is 0 and the divider value is 4, and neither tick output pulses.
- R2: When the select bit is 0 and the generator value is G ≥ 1, `sample_tick` is high for exactly one cycle in every G clock cycles. When G = 1 it is high on every cycle.
- R3: When the select bit is 1, the clock is first thinned to one enabled cycle in eight, so sample ticks come every 8·G clock cycles.
- R4: `bit_tick` pulses on every (D+1)-th sample tick, and only in the same cycle as that sample tick. D is the divider value.
- R5: A divider value below 4 behaves exactly like a divider value of 4, which gives a bit tick every 5 sample ticks.
- R6: While the generator value is 0, neither tick output pulses.
- R7: A write to the generator value or the divider value clears every counter. The first sample tick is then due one full period after the write edge, whatever count was in progress before the write.
- R8: `bit_tick` is never high for two cycles in a row.
- R9: A write to the select bit also clears every counter. The first sample tick after switching to the divide-by-8 source comes 8·G cycles after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_wr | input | 1 | Write strobe for the clock-select bit |
| sel_in | input | 1 | Clock select: 0 = reference clock, 1 = reference clock / 8 |
| gen_wr | input | 1 | Write strobe for the generator value |
| gen_in | input | 16 | Generator value; 0 stops all ticks |
| div_wr | input | 1 | Write strobe for the divider value |
| div_in | input | 8 | Divider value; bit tick every div+1 sample ticks (minimum 4) |
| sample_tick | output | 1 | One-cycle oversampling strobe |
| bit_tick | output | 1 | One-cycle bit-rate strobe |

## Verification
Every result is timed from the clock edge that captures a write, where all counters restart. With the direct source, the first sample tick is visible after G further edges; with the divide-by-8 source it is visible after 8·G edges. The first bit tick is visible after G·(D+1) edges, or 8 times that with the divide-by-8 source, and each later tick follows at the same spacing. The bench raises each strobe for exactly one edge. It then samples the outputs on every falling edge and counts those falling edges, so a measured distance of k means the tick became visible after the k-th rising edge. It compares that count with the exact figure worked out from the written values.

// File: rtl/baud_gen2_pkg.sv
package baud_gen2_pkg;
  localparam int unsigned GEN_WIDTH   = 16;
  localparam int unsigned DIV_WIDTH   = 8;
  localparam int unsigned PRE_WIDTH   = 3;   // 2**PRE_WIDTH = prescale ratio
  localparam int unsigned DIV_FLOOR   = 4;
  localparam int unsigned DIV_RESET   = 4;
endpackage

// File: rtl/baud_gen2_prescale.sv
module baud_gen2_prescale #(
  parameter int unsigned PRE_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  input  logic bypass,
  output logic step_en
);
  logic [PRE_W-1:0] phase_q, phase_d;

  always_comb begin
    if (reload) phase_d = '0;
    else        phase_d = phase_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign step_en = bypass | (&phase_q);

  // R3: with the divide-by-8 source, an enable is followed by a quiet cycle
  a_r3_pre_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !bypass && !reload) |=> !step_en);
endmodule

// File: rtl/baud_gen2_sample_ctr.sv
module baud_gen2_sample_ctr #(
  parameter int unsigned GEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic             step_en,
  input  logic [GEN_W-1:0] gen_val,
  output logic             fire,
  output logic             tick
);
  logic [GEN_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;
  logic             active;
  logic [GEN_W-1:0] last_cnt;

  assign active   = step_en && (gen_val != '0) && !reload;
  assign last_cnt = gen_val - GEN_W'(1);
  assign fire     = active && (cnt_q == last_cnt);

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = fire;
    if (reload)      cnt_d = '0;
    else if (active) cnt_d = fire ? '0 : cnt_q + GEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  // R6: a zero generator value keeps the sample strobe low
  a_r6_idle_when_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_val == '0) |-> !tick_q);
endmodule

// File: rtl/baud_gen2_bit_ctr.sv
module baud_gen2_bit_ctr #(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned DIV_MIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic             step,
  input  logic             sample_tick,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] limit;
  logic             hit;
  logic             tick_q;

  assign limit = (div_val < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : div_val;
  assign hit   = step && !reload && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (reload)    cnt_d = '0;
    else if (step) cnt_d = hit ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= hit;
    end
  end

  assign tick = tick_q;

  // R4: a bit strobe only appears together with a sample strobe
  a_r4_bit_with_sample: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> sample_tick);
  // R8: bit strobe never lasts two cycles
  a_r8_bit_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);
endmodule

// File: rtl/baud_gen2.sv
module baud_gen2
  import baud_gen2_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_wr,
  input  logic        sel_in,
  input  logic        gen_wr,
  input  logic [15:0] gen_in,
  input  logic        div_wr,
  input  logic [7:0]  div_in,
  output logic        sample_tick,
  output logic        bit_tick
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic                 sel_q, sel_d;
  logic [GEN_WIDTH-1:0] gen_q, gen_d;
  logic [DIV_WIDTH-1:0] div_q, div_d;
  logic                 reload;
  logic                 step_en;
  logic                 fire;

  assign reload = sel_wr | gen_wr | div_wr;

  always_comb begin
    sel_d = sel_wr ? sel_in : sel_q;
    gen_d = gen_wr ? gen_in : gen_q;
    div_d = div_wr ? div_in : div_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sel_q <= 1'b0;
      gen_q <= '0;
      div_q <= DIV_WIDTH'(DIV_RESET);
    end else begin
      sel_q <= sel_d;
      gen_q <= gen_d;
      div_q <= div_d;
    end
  end

  baud_gen2_prescale #(.PRE_W(PRE_WIDTH)) u_pre (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .reload  (reload),
    .bypass  (!sel_q),
    .step_en (step_en)
  );

  baud_gen2_sample_ctr #(.GEN_W(GEN_WIDTH)) u_smp (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .reload  (reload),
    .step_en (step_en),
    .gen_val (gen_q),
    .fire    (fire),
    .tick    (sample_tick)
  );

  baud_gen2_bit_ctr #(.DIV_W(DIV_WIDTH), .DIV_MIN(DIV_FLOOR)) u_bit (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .reload      (reload),
    .step        (fire),
    .sample_tick (sample_tick),
    .div_val     (div_q),
    .tick        (bit_tick)
  );

  // R7, R9: the cycle after any write shows no strobe
  a_r7_reload_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reload |=> (!sample_tick && !bit_tick));
endmodule

// File: tb/test_baud_gen2.sv
module test_baud_gen2;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_wr = 1'b0, sel_in = 1'b0;
  logic        gen_wr = 1'b0, div_wr = 1'b0;
  logic [15:0] gen_in = '0;
  logic [7:0]  div_in = '0;
  logic        sample_tick, bit_tick;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4ns clk = ~clk;

  baud_gen2 i_baud_gen2 (
    .clk(clk), .rst_n(rst_n),
    .sel_wr(sel_wr), .sel_in(sel_in),
    .gen_wr(gen_wr), .gen_in(gen_in),
    .div_wr(div_wr), .div_in(div_in),
    .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // each write: strobe held for one rising edge, released at the next falling edge
  task automatic wr_sel(input logic v);
    @(negedge clk); sel_in = v; sel_wr = 1'b1;
    @(posedge clk); @(negedge clk); sel_wr = 1'b0;
  endtask
  task automatic wr_gen(input int v);
    @(negedge clk); gen_in = 16'(v); gen_wr = 1'b1;
    @(posedge clk); @(negedge clk); gen_wr = 1'b0;
  endtask
  task automatic wr_div(input int v);
    @(negedge clk); div_in = 8'(v); div_wr = 1'b1;
    @(posedge clk); @(negedge clk); div_wr = 1'b0;
  endtask

  // falling edges until the chosen strobe is seen high; -1 if never
  task automatic gap(input bit use_bit, input int limit, output int k);
    k = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (use_bit ? bit_tick : sample_tick) begin k = i; break; end
    end
  endtask

  task automatic t_reset;
    int seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      seen += int'(sample_tick) + int'(bit_tick);
    end
    check("R1 no ticks after reset", seen, 0);
  endtask

  task automatic t_direct;
    int k;
    wr_sel(1'b0); wr_gen(3);
    gap(1'b0, 100, k); check("R2/R7 first sample G=3", k, 3);
    gap(1'b0, 100, k); check("R2 next sample G=3", k, 3);
    wr_gen(1);
    gap(1'b0, 100, k); check("R2 first sample G=1", k, 1);
    gap(1'b0, 100, k); check("R2 next sample G=1", k, 1);
  endtask

  task automatic t_prescale;
    int k;
    wr_sel(1'b1); wr_gen(2);
    gap(1'b0, 200, k); check("R3 first sample /8 G=2", k, 16);
    gap(1'b0, 200, k); check("R3 next sample /8 G=2", k, 16);
    wr_sel(1'b0);
  endtask

  task automatic t_bits;
    int k;
    wr_gen(2); wr_div(6);
    gap(1'b1, 500, k); check("R4 first bit G=2 D=6", k, 14);
    check("R4 sample with bit", int'(sample_tick), 1);
    @(negedge clk); check("R8 bit single cycle", int'(bit_tick), 0);
    gap(1'b1, 500, k); check("R4 next bit G=2 D=6", k, 13);
    wr_gen(1); wr_div(255);
    gap(1'b1, 1000, k); check("R4 first bit G=1 D=255", k, 256);
  endtask

  task automatic t_floor;
    int k;
    wr_gen(2); wr_div(0);
    gap(1'b1, 500, k); check("R5 div 0 acts as 4", k, 10);
    wr_div(3);
    gap(1'b1, 500, k); check("R5 div 3 acts as 4", k, 10);
  endtask

  task automatic t_stop;
    int k;
    wr_gen(0);
    gap(1'b0, 300, k); check("R6 no sample with gen 0", k, -1);
    wr_gen(0);
    gap(1'b1, 300, k); check("R6 no bit with gen 0", k, -1);
  endtask

  task automatic t_reload;
    int k;
    wr_div(4); wr_gen(10);
    repeat (5) @(negedge clk);
    wr_gen(10);
    gap(1'b0, 100, k); check("R7 gen rewrite restarts", k, 10);
    repeat (3) @(negedge clk);
    wr_div(4);
    gap(1'b0, 100, k); check("R7 div rewrite restarts", k, 10);
    wr_gen(4);
    repeat (2) @(negedge clk);
    wr_sel(1'b1);
    gap(1'b0, 100, k); check("R9 select write restarts", k, 32);
  endtask

  initial begin
    #(8ns * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_direct();
    t_prescale();
    t_bits();
    t_floor();
    t_stop();
    t_reload();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule